// File: doc/BRIEF.md
# Bitstream File Header Parser

This block reads the start of a device configuration file as it arrives one byte at a time over a valid/ready stream. It first checks that the file opens with a fixed 13-byte signature. It then walks the tagged sections that follow until it finds the section letter requested at start, and reports that section's length. The parser stops taking bytes straight after the length field of the matching section. The section's content therefore stays at the head of the stream for whatever consumes it next, for example a loader that clocks the payload into a device.

Each section is laid out as a one-byte ASCII letter, a big-endian length, and then that many content bytes. The letter `e` (0x65) carries a four-byte length; every other letter carries a two-byte length. Sections that do not match are skipped. Several sanity limits can end the search early: a letter outside the accepted range, an oversized short length, or a byte budget for the whole scan. A stream that begins with the gzip magic is detected and flagged but not unpacked. Each search ends with a one-cycle `done` pulse and exactly one outcome flag, and the flags and length hold until the next search starts.

Top module: `bitfile_hdr_scan`

## Requirements
- R1: The first 13 bytes must equal 00 09 0F F0 0F F0 0F F0 0F F0 00 00 01. At the first byte that matches neither this signature nor the compressed signature, the search ends with `err`. That byte is consumed and no further byte is taken.
- R2: A stream whose first three bytes are 1F 8B 08 ends the search with `gz` after exactly those three bytes are consumed.
- R3: After the signature, each section is a type byte followed by a big-endian length: 4 bytes when the type is 0x65 (`e`), 2 bytes otherwise. When the type equals the requested letter, the search ends with `found` and `sec_len` equal to the length. No byte past the length field is consumed, and `in_ready` is low when `done` pulses.
- R4: A type byte below 0x61 or above 0x65 ends the search with `miss`. That type byte is consumed.
- R5: A section with a two-byte length greater than 255 ends the search with `err` once its length field is consumed, even if its letter was requested.
- R6: The content bytes of a non-matching section are consumed and discarded, and the search continues with the next type byte. A zero length goes straight to the next type byte.
- R7: At most SCAN_LIMIT (default 100) bytes are taken after the signature. If the search needs a further byte, it ends with `miss` without taking it, so no search consumes more than 13 + SCAN_LIMIT bytes.
- R8: `done` is a one-cycle pulse. While it is high exactly one of `found`, `miss`, `err`, `gz` is set. The flags and `sec_len` then hold until the next accepted start; `sec_len` is 0 for any outcome other than `found`.
- R9: The requested letter is captured when a search is started. A `start` pulse or a change on `want_sec` during a search has no effect on that search.
- R10: After reset `in_ready`, `done`, all outcome flags and `sec_len` are 0, and `in_ready` stays low while no search runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a search; taken only when idle (including the `done` cycle) |
| want_sec | input | 8 | ASCII letter of the section to find, captured at start |
| in_valid | input | 1 | Stream byte valid |
| in_data | input | 8 | Stream byte |
| in_ready | output | 1 | Parser accepts the stream byte this cycle |
| done | output | 1 | One-cycle pulse at the end of a search |
| found | output | 1 | Requested section located; its length is on `sec_len` |
| miss | output | 1 | Section not present, bad letter, or byte budget used up |
| err | output | 1 | Signature mismatch or oversized short length |
| gz | output | 1 | Stream carries the compressed-image magic |
| sec_len | output | 32 | Length of the found section |

## Verification
The assertions check on every cycle that each end pulse carries exactly one outcome, that the results stay still between pulses, that the stream is never taken while idle or at the end pulse, that a compressed stream ends after exactly three accepted bytes, and that no search takes more than the signature plus the byte budget. Only the bench scenarios can show that the right outcome and length come from a given byte pattern. These scenarios cover long and short length fields, skipped content, bad letters, oversized lengths, a broken signature at a chosen position, and a budget run out either during a skip or at a type byte. The bench also shows that a repeated start or a changed letter during a search is ignored, by placing a decoy section ahead of the requested one.

// File: rtl/bhp_pkg.sv
// Shared definitions for the bitstream header parser: scan states,
// outcome codes, fixed signature bytes and section-letter constants.
// Assumes the signature and compressed magic are fixed by the file format.
package bhp_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PRE,
        ST_TYPE,
        ST_LEN,
        ST_SKIP
    } scan_st_t;

    typedef enum logic [1:0] {
        OUT_HIT,
        OUT_MISS,
        OUT_ERR,
        OUT_GZ
    } scan_out_t;

    localparam int SIG_LEN = 13;
    localparam int GZ_LEN  = 3;

    localparam logic [7:0] SEC_FIRST = 8'h61;
    localparam logic [7:0] SEC_LAST  = 8'h65;
    localparam logic [7:0] SEC_LONG  = 8'h65;

    // Signature byte at a given position.
    function automatic logic [7:0] sig_byte(input logic [3:0] idx);
        logic [7:0] b;
        case (idx)
            4'd1:                         b = 8'h09;
            4'd2, 4'd4, 4'd6, 4'd8:       b = 8'h0F;
            4'd3, 4'd5, 4'd7, 4'd9:       b = 8'hF0;
            4'd12:                        b = 8'h01;
            default:                      b = 8'h00;
        endcase
        return b;
    endfunction

    // Compressed-image magic byte at a given position.
    function automatic logic [7:0] gz_byte(input logic [3:0] idx);
        logic [7:0] b;
        case (idx)
            4'd0:    b = 8'h1F;
            4'd1:    b = 8'h8B;
            default: b = 8'h08;
        endcase
        return b;
    endfunction

endpackage

// File: rtl/bhp_magic_match.sv
// Tracks the opening bytes against both the fixed signature and the
// compressed magic. Match results for the current byte are combinational
// so that the top can end the search on the very byte that breaks both.
// Assumes 'step' is raised only for accepted bytes during the opening phase.
module bhp_magic_match
    import bhp_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clear,
    input  logic       step,
    input  logic [7:0] byte_i,
    output logic       sig_live_o,
    output logic       gz_live_o,
    output logic       sig_last_o,
    output logic       gz_last_o
);

    logic [3:0] idx_q;
    logic       sig_alive_q;
    logic       gz_alive_q;

    // Current-byte match against both candidate openings.
    always_comb begin
        sig_live_o = sig_alive_q && (byte_i == sig_byte(idx_q));
        gz_live_o  = gz_alive_q && (idx_q < 4'(GZ_LEN)) && (byte_i == gz_byte(idx_q));
        sig_last_o = (idx_q == 4'(SIG_LEN - 1));
        gz_last_o  = (idx_q == 4'(GZ_LEN - 1));
    end

    // Position counter and survival flags for each candidate.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q       <= '0;
            sig_alive_q <= 1'b0;
            gz_alive_q  <= 1'b0;
        end else if (clear) begin
            idx_q       <= '0;
            sig_alive_q <= 1'b1;
            gz_alive_q  <= 1'b1;
        end else if (step) begin
            idx_q       <= idx_q + 4'd1;
            sig_alive_q <= sig_live_o;
            gz_alive_q  <= gz_live_o;
        end
    end

endmodule

// File: rtl/bhp_len_shift.sv
// Assembles a big-endian length field one byte at a time. The value that
// includes the byte on the input is offered combinationally so the top can
// judge the complete length on the cycle its last byte is accepted.
// Assumes 'clear' precedes each new field.
module bhp_len_shift #(
    parameter int LEN_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             shift,
    input  logic [7:0]       byte_i,
    output logic [LEN_W-1:0] next_o
);

    logic [LEN_W-1:0] val_q;

    // Value including the byte now on the input.
    always_comb begin
        next_o = {val_q[LEN_W-9:0], byte_i};
    end

    // Accumulator register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            val_q <= '0;
        end else if (clear) begin
            val_q <= '0;
        end else if (shift) begin
            val_q <= next_o;
        end
    end

endmodule

// File: rtl/bhp_budget.sv
// Counts bytes taken after the signature and reports when the scan budget
// is used up. Assumes 'inc' is never raised once 'spent_o' is high.
module bhp_budget #(
    parameter int LIMIT = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic inc,
    output logic spent_o
);

    localparam int CNT_W = $clog2(LIMIT + 1);

    logic [CNT_W-1:0] cnt_q;

    // Budget exhausted flag.
    always_comb begin
        spent_o = (cnt_q >= CNT_W'(LIMIT));
    end

    // Byte counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clear) begin
            cnt_q <= '0;
        end else if (inc) begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end

endmodule

// File: rtl/bitfile_hdr_scan.sv
// Top of the bitstream header parser. Checks the opening signature, then
// walks type/length/content sections until the requested letter is found,
// a sanity limit trips, or the byte budget runs out. Stops consuming right
// after the matching length field. Assumes one search at a time; start is
// honoured only while idle.
module bitfile_hdr_scan
    import bhp_pkg::*;
#(
    parameter int LEN_W      = 32,
    parameter int SCAN_LIMIT = 100,
    parameter int SHORT_MAX  = 255
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [7:0]       want_sec,
    input  logic             in_valid,
    input  logic [7:0]       in_data,
    output logic             in_ready,
    output logic             done,
    output logic             found,
    output logic             miss,
    output logic             err,
    output logic             gz,
    output logic [LEN_W-1:0] sec_len
);

    localparam int LB_W = 3;

    scan_st_t         state_q, state_d;
    scan_out_t        code;
    logic             fin;
    logic [7:0]       want_q;
    logic [7:0]       type_q;
    logic [LB_W-1:0]  lrem_q;
    logic [LEN_W-1:0] skip_q;

    logic             launch, take, in_body, spent;
    logic             sig_live, gz_live, sig_last, gz_last;
    logic             type_ok;
    logic [LEN_W-1:0] len_next;

    bhp_magic_match u_magic (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (launch),
        .step       (take && (state_q == ST_PRE)),
        .byte_i     (in_data),
        .sig_live_o (sig_live),
        .gz_live_o  (gz_live),
        .sig_last_o (sig_last),
        .gz_last_o  (gz_last)
    );

    bhp_len_shift #(.LEN_W(LEN_W)) u_len (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (take && (state_q == ST_TYPE)),
        .shift  (take && (state_q == ST_LEN)),
        .byte_i (in_data),
        .next_o (len_next)
    );

    bhp_budget #(.LIMIT(SCAN_LIMIT)) u_budget (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (launch),
        .inc     (take && in_body),
        .spent_o (spent)
    );

    // Handshake and phase decode.
    always_comb begin
        launch   = start && (state_q == ST_IDLE);
        in_body  = (state_q == ST_TYPE) || (state_q == ST_LEN) || (state_q == ST_SKIP);
        in_ready = (state_q == ST_PRE) || (in_body && !spent);
        take     = in_valid && in_ready;
        type_ok  = (in_data >= SEC_FIRST) && (in_data <= SEC_LAST);
    end

    // Next state and end-of-search outcome.
    always_comb begin
        state_d = state_q;
        fin     = 1'b0;
        code    = OUT_MISS;
        case (state_q)
            ST_IDLE: begin
                if (start) state_d = ST_PRE;
            end
            ST_PRE: begin
                if (take) begin
                    if (!sig_live && !gz_live) begin
                        fin  = 1'b1;
                        code = OUT_ERR;
                    end else if (gz_live && gz_last) begin
                        fin  = 1'b1;
                        code = OUT_GZ;
                    end else if (sig_live && sig_last) begin
                        state_d = ST_TYPE;
                    end
                end
            end
            ST_TYPE: begin
                if (spent) begin
                    fin = 1'b1;
                end else if (take) begin
                    if (!type_ok) fin = 1'b1;
                    else          state_d = ST_LEN;
                end
            end
            ST_LEN: begin
                if (spent) begin
                    fin = 1'b1;
                end else if (take && (lrem_q == LB_W'(1))) begin
                    if ((type_q != SEC_LONG) && (len_next > LEN_W'(SHORT_MAX))) begin
                        fin  = 1'b1;
                        code = OUT_ERR;
                    end else if (type_q == want_q) begin
                        fin  = 1'b1;
                        code = OUT_HIT;
                    end else if (len_next == '0) begin
                        state_d = ST_TYPE;
                    end else begin
                        state_d = ST_SKIP;
                    end
                end
            end
            ST_SKIP: begin
                if (spent) begin
                    fin = 1'b1;
                end else if (take && (skip_q == LEN_W'(1))) begin
                    state_d = ST_TYPE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
        if (fin) state_d = ST_IDLE;
    end

    // State, section bookkeeping and result registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            want_q  <= '0;
            type_q  <= '0;
            lrem_q  <= '0;
            skip_q  <= '0;
            done    <= 1'b0;
            found   <= 1'b0;
            miss    <= 1'b0;
            err     <= 1'b0;
            gz      <= 1'b0;
            sec_len <= '0;
        end else begin
            state_q <= state_d;
            done    <= fin;
            if (launch) begin
                want_q  <= want_sec;
                found   <= 1'b0;
                miss    <= 1'b0;
                err     <= 1'b0;
                gz      <= 1'b0;
                sec_len <= '0;
            end
            if (fin) begin
                case (code)
                    OUT_HIT: begin
                        found   <= 1'b1;
                        sec_len <= len_next;
                    end
                    OUT_ERR:  err  <= 1'b1;
                    OUT_GZ:   gz   <= 1'b1;
                    default:  miss <= 1'b1;
                endcase
            end
            if (take && (state_q == ST_TYPE)) begin
                type_q <= in_data;
                lrem_q <= (in_data == SEC_LONG) ? LB_W'(4) : LB_W'(2);
            end
            if (take && (state_q == ST_LEN)) begin
                lrem_q <= lrem_q - LB_W'(1);
                if (lrem_q == LB_W'(1)) skip_q <= len_next;
            end
            if (take && (state_q == ST_SKIP)) begin
                skip_q <= skip_q - LEN_W'(1);
            end
        end
    end

endmodule

// File: rtl/bhp_checker.sv
// Protocol checks for the bitstream header parser, observed at its ports.
// Keeps its own idea of whether a search runs and how many bytes it took.
module bhp_checker #(
    parameter int LEN_W      = 32,
    parameter int SCAN_LIMIT = 100
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic             in_valid,
    input logic             in_ready,
    input logic             done,
    input logic             found,
    input logic             miss,
    input logic             err,
    input logic             gz,
    input logic [LEN_W-1:0] sec_len
);

    logic        busy_q;
    logic [15:0] cnt_q;
    logic        acc_start;

    // A start is taken when no search runs or one is just ending.
    always_comb begin
        acc_start = start && (!busy_q || done);
    end

    // Search tracking and accepted-byte count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
        end else begin
            busy_q <= acc_start ? 1'b1 : (done ? 1'b0 : busy_q);
            if (acc_start)                 cnt_q <= '0;
            else if (in_valid && in_ready) cnt_q <= cnt_q + 16'd1;
        end
    end

    // R8
    one_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $onehot({found, miss, err, gz}));

    // R8
    results_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> (done || $stable({found, miss, err, gz, sec_len})));

    // R3
    stop_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !in_ready);

    // R10
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_q |-> !in_ready);

    // R2
    gz_three_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && gz) |-> (cnt_q == 16'd3));

    // R7
    budget_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= 16'(13 + SCAN_LIMIT));

endmodule

bind bitfile_hdr_scan bhp_checker #(.LEN_W(LEN_W), .SCAN_LIMIT(SCAN_LIMIT)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .done     (done),
    .found    (found),
    .miss     (miss),
    .err      (err),
    .gz       (gz),
    .sec_len  (sec_len)
);

// File: tb/bitfile_hdr_scan_tb_top.sv
`timescale 1ns/1ps
module bitfile_hdr_scan_tb_top;

    localparam int LIMIT = 100;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [7:0]  want_sec = 8'h00;
    logic        in_valid = 1'b0;
    logic [7:0]  in_data = 8'h00;
    logic        in_ready, done, found, miss, err, gz;
    logic [31:0] sec_len;

    int n_chk = 0;
    int n_bad = 0;
    int cycles = 0;

    logic [7:0] mem [0:1023];
    int         n;

    localparam logic [7:0] SIG [0:12] = '{8'h00, 8'h09, 8'h0F, 8'hF0, 8'h0F, 8'hF0,
                                          8'h0F, 8'hF0, 8'h0F, 8'hF0, 8'h00, 8'h00, 8'h01};

    bitfile_hdr_scan dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .want_sec(want_sec),
        .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
        .done(done), .found(found), .miss(miss), .err(err), .gz(gz),
        .sec_len(sec_len)
    );

    always #4 clk = ~clk;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: run hung, actual cycles %0d expected < 150000", cycles);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    task automatic chk(input string req, input string what, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic put(input logic [7:0] b);
        mem[n] = b;
        n++;
    endtask

    task automatic put_sig();
        for (int i = 0; i < 13; i++) put(SIG[i]);
    endtask

    task automatic put_sec(input logic [7:0] t, input logic [31:0] len, input int body);
        put(t);
        if (t == 8'h65) begin
            put(len[31:24]);
            put(len[23:16]);
        end
        put(len[15:8]);
        put(len[7:0]);
        for (int i = 0; i < body; i++) put(8'(i + 8'h30));
    endtask

    task automatic pad();
        for (int i = 0; i < 130; i++) put(8'h7A);
    endtask

    // Reference outcome: 0 found, 1 miss, 2 err, 3 gz.
    function automatic void model(input logic [7:0] want, output int code,
                                  output longint len, output int used);
        bit sig_ok = 1, gz_ok = 1;
        int p = 0, cnt = 0, nl;
        logic [7:0] t;
        logic [31:0] l;
        len = 0;
        for (int k = 0; k < 13; k++) begin
            sig_ok = sig_ok && (mem[k] == SIG[k]);
            gz_ok  = gz_ok && (k < 3) && (mem[k] == (k == 0 ? 8'h1F : (k == 1 ? 8'h8B : 8'h08)));
            if (!sig_ok && !gz_ok) begin code = 2; used = k + 1; return; end
            if (gz_ok && k == 2) begin code = 3; used = 3; return; end
        end
        p = 13;
        forever begin
            if (cnt == LIMIT) begin code = 1; used = p; return; end
            t = mem[p]; p++; cnt++;
            if (t < 8'h61 || t > 8'h65) begin code = 1; used = p; return; end
            nl = (t == 8'h65) ? 4 : 2;
            l = 0;
            for (int j = 0; j < nl; j++) begin
                if (cnt == LIMIT) begin code = 1; used = p; return; end
                l = {l[23:0], mem[p]}; p++; cnt++;
            end
            if (t != 8'h65 && l > 255) begin code = 2; used = p; return; end
            if (t == want) begin code = 0; len = l; used = p; return; end
            for (longint j = 0; j < l; j++) begin
                if (cnt == LIMIT) begin code = 1; used = p; return; end
                p++; cnt++;
            end
        end
    endfunction

    // Run one search over mem; inject_at >= 0 pulses start and changes the letter mid-run.
    task automatic run_case(input string req, input logic [7:0] want, input int inject_at);
        int p = 0, cyc = 0, ecode, eused, acode;
        longint elen;
        bit got = 0, hs, inj_done = 0, rdy_at_done = 1;
        model(want, ecode, elen, eused);
        @(negedge clk);
        start = 1'b1;
        want_sec = want;
        @(negedge clk);
        start = 1'b0;
        while (!got && cyc < 4000) begin
            if (done) begin
                got = 1;
                rdy_at_done = in_ready;
            end else begin
                if (inject_at >= 0 && p == inject_at && !inj_done) begin
                    start = 1'b1;
                    want_sec = 8'h62;
                    inj_done = 1;
                end else begin
                    start = 1'b0;
                end
                in_valid = (p < n) && ($urandom_range(0, 3) != 0);
                in_data  = (p < n) ? mem[p] : 8'h00;
                #1;
                hs = in_valid && in_ready;
                @(posedge clk);
                if (hs) p++;
                @(negedge clk);
                cyc++;
            end
        end
        in_valid = 1'b0;
        start = 1'b0;
        chk(req, "done seen", got, 1);
        acode = found ? 0 : (miss ? 1 : (err ? 2 : (gz ? 3 : 9)));
        chk(req, "outcome", acode, ecode);
        chk(req, "sec_len", sec_len, elen);
        chk(req, "bytes consumed", p, eused);
        chk("R3", "in_ready at done", rdy_at_done, 0);
        @(negedge clk);
        chk("R8", "done pulse width", done, 0);
    endtask

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        chk("R10", "reset in_ready", in_ready, 0);
        chk("R10", "reset done", done, 0);
        chk("R10", "reset flags", {found, miss, err, gz}, 0);
        chk("R10", "reset sec_len", sec_len, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R10", "idle in_ready", in_ready, 0);

        // R3 first section found, short length
        n = 0; put_sig(); put_sec(8'h61, 10, 10); pad();
        run_case("R3", 8'h61, -1);

        // R3 R6 long length found after skipped sections
        n = 0; put_sig(); put_sec(8'h61, 4, 4); put_sec(8'h62, 3, 3);
        put_sec(8'h63, 0, 0); put_sec(8'h64, 2, 2); put_sec(8'h65, 32'h0001_2345, 0); pad();
        run_case("R3", 8'h65, -1);

        // R1 broken signature at position 5
        n = 0; put_sig(); mem[5] = 8'hAA; pad();
        run_case("R1", 8'h61, -1);

        // R1 broken signature at the last byte
        n = 0; put_sig(); mem[12] = 8'h02; pad();
        run_case("R1", 8'h61, -1);

        // R2 compressed magic
        n = 0; put(8'h1F); put(8'h8B); put(8'h08); pad();
        run_case("R2", 8'h61, -1);

        // R1 partial compressed magic
        n = 0; put(8'h1F); put(8'h8B); put(8'h09); pad();
        run_case("R1", 8'h61, -1);

        // R4 letter out of range
        n = 0; put_sig(); put_sec(8'h62, 1, 1); put(8'h66); pad();
        run_case("R4", 8'h61, -1);

        // R5 oversized short length on requested letter
        n = 0; put_sig(); put_sec(8'h63, 256, 0); pad();
        run_case("R5", 8'h63, -1);

        // R7 budget runs out inside a huge skip
        n = 0; put_sig(); put_sec(8'h65, 32'h0001_0000, 0); pad();
        run_case("R7", 8'h64, -1);

        // R7 budget runs out among empty sections
        n = 0; put_sig();
        for (int i = 0; i < 40; i++) put_sec(8'h62, 0, 0);
        pad();
        run_case("R7", 8'h61, -1);

        // R9 restart and letter change mid-search ignored (decoy 'b' first)
        n = 0; put_sig(); put_sec(8'h62, 5, 5); put_sec(8'h63, 7, 7); pad();
        run_case("R9", 8'h63, 8);

        // R6 R8 random section sequences
        for (int r = 0; r < 60; r++) begin
            int ns = $urandom_range(1, 8);
            n = 0;
            case ($urandom_range(0, 9))
                0: begin put_sig(); mem[$urandom_range(0, 12)] = 8'(8'h40 + $urandom_range(0, 9)); end
                1: begin put(8'h1F); put(8'h8B); put(8'h08); end
                default: put_sig();
            endcase
            for (int s = 0; s < ns; s++) begin
                logic [7:0] t = 8'(8'h61 + $urandom_range(0, 4));
                int l = $urandom_range(0, 12);
                if ($urandom_range(0, 19) == 0) t = 8'h67;
                if ($urandom_range(0, 24) == 0) put_sec(t, 300, 0);
                else put_sec(t, l, l);
            end
            pad();
            run_case("R6", 8'(8'h61 + $urandom_range(0, 4)), -1);
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule